// File: doc/BRIEF.md
# Fused Matrix Load Sequencer

This block fills the local operand buffers of a matrix-multiply engine and later empties its result buffer. A single two-level loop walks a grid of max(M,N) rows by max(N,K) columns. On each grid point it does up to three things, each behind its own bounds guard: it fetches one element of A over the A read port, fetches one element of B over the B read port, and clears one element of the C buffer. Both reads of a grid point go out in the same cycle on their own ports, and the point's buffer writes also share one cycle. This merges what would otherwise be three separate passes.

Software programs three base addresses and a start bit through a small register file. When the last grid point retires, the block pulses a load-complete flag. It then waits for the compute engine's completion pulse. After that pulse it reads the C buffer in row-major order and writes one element per cycle to memory through a third port. Every memory address is base + (row·columns + column)·element_bytes.

Top module: `matfuse_loader`

## Requirements
- R1: Register offsets 0x10, 0x1C and 0x28 hold the A, B and C base addresses. A read returns the selected register one cycle after `cfg_addr` is presented. Any offset that is not mapped reads as zero.
- R2: Writing offset 0x00 with bit 0 set starts a run when the block is idle. The same write during a run is ignored.
- R3: Offset 0x00 reads back bit 0 = busy and bit 1 = done. Done sets when the write-back of C finishes and clears on the next accepted start.
- R4: The grid is walked row-major (i outer over max(M,N), j inner over max(N,K)). At a grid point with i<M and j<N, the block requests A at base_A+(i·N+j)·ES and writes the response to the A buffer at (i,j). No other point touches A.
- R5: At a grid point with i<N and j<K, the block requests B at base_B+(i·K+j)·ES and writes the response to the B buffer at (i,j). No other point touches B.
- R6: At a grid point with i<M and j<K, the block strobes a clear of C buffer cell (i,j). Every such cell is cleared exactly once per run.
- R7: Both reads of a grid point are issued in the same cycle. The point retires only after every response it needs has arrived, whatever the latency of each port. All buffer strobes of a point share one cycle and carry the same (i,j).
- R8: `load_done` is high for exactly one cycle per run, in the same cycle as the strobes of the last grid point.
- R9: `calc_done` is acted on only after `load_done`, and is ignored at any other time. The write-back then reads the C buffer (data returned one cycle after `c_rd_en`) and writes one element per consecutive cycle to base_C+(r·K+c)·ES, row-major, carrying the buffer data. It never overlaps an A or B request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | AW (32) | Register write data |
| cfg_rdata | output | AW (32) | Register read data, one cycle after address |
| a_req_valid | output | 1 | A read request |
| a_req_addr | output | AW (32) | A read address |
| a_rsp_valid | input | 1 | A read response valid |
| a_rsp_data | input | DW (16) | A read response data |
| b_req_valid | output | 1 | B read request |
| b_req_addr | output | AW (32) | B read address |
| b_rsp_valid | input | 1 | B read response valid |
| b_rsp_data | input | DW (16) | B read response data |
| c_wr_valid | output | 1 | C memory write strobe |
| c_wr_addr | output | AW (32) | C memory write address |
| c_wr_data | output | DW (16) | C memory write data |
| a_buf_we | output | 1 | A buffer write strobe |
| a_buf_row | output | RW (2) | A buffer row |
| a_buf_col | output | CW (3) | A buffer column |
| a_buf_data | output | DW (16) | A buffer write data |
| b_buf_we | output | 1 | B buffer write strobe |
| b_buf_row | output | RW (2) | B buffer row |
| b_buf_col | output | CW (3) | B buffer column |
| b_buf_data | output | DW (16) | B buffer write data |
| c_clr_we | output | 1 | C buffer clear strobe |
| c_clr_row | output | RW (2) | C buffer clear row |
| c_clr_col | output | CW (3) | C buffer clear column |
| load_done | output | 1 | One-cycle pulse at end of load |
| calc_done | input | 1 | Compute-finished pulse that starts write-back |
| c_rd_en | output | 1 | C buffer read enable |
| c_rd_row | output | RW (2) | C buffer read row |
| c_rd_col | output | CW (3) | C buffer read column |
| c_rd_data | input | DW (16) | C buffer read data, one cycle after `c_rd_en` |

## Verification
The A and B buffer writes of one grid point are meant to fire in the same cycle. With M=3, N=4 and K=5, exactly twelve grid points need both. The bench provokes this with equal port latencies and with both skews (A slower, B slower), so responses arrive in different cycles. It counts the cycles in which both strobes are high and requires exactly twelve. It also requires every buffer cell to be written once with the data that belongs to its computed address. An assertion checks that the row and column of simultaneous strobes agree.

// File: rtl/mfl_pkg.sv
package mfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_HOLD, ST_WB, ST_DRAIN
  } seq_st_t;

  localparam logic [5:0] OFS_CTRL   = 6'h00;
  localparam logic [5:0] OFS_BASE_A = 6'h10;
  localparam logic [5:0] OFS_BASE_B = 6'h1C;
  localparam logic [5:0] OFS_BASE_C = 6'h28;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/mfl_regs.sv
module mfl_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          done_set,
  output logic          start_o,
  output logic [AW-1:0] base_a_o,
  output logic [AW-1:0] base_b_o,
  output logic [AW-1:0] base_c_o,
  output logic          done_o
);
  import mfl_pkg::*;

  logic active;
  assign active = busy | start_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o   <= 1'b0;
      done_o    <= 1'b0;
      base_a_o  <= '0;
      base_b_o  <= '0;
      base_c_o  <= '0;
      cfg_rdata <= '0;
    end else begin
      start_o <= 1'b0;
      if (done_set) done_o <= 1'b1;
      if (cfg_we) begin
        case (cfg_addr)
          OFS_CTRL: if (cfg_wdata[0] && !active) begin
            start_o <= 1'b1;
            done_o  <= 1'b0;
          end
          OFS_BASE_A: base_a_o <= cfg_wdata;
          OFS_BASE_B: base_b_o <= cfg_wdata;
          OFS_BASE_C: base_c_o <= cfg_wdata;
          default: ;
        endcase
      end
      case (cfg_addr)
        OFS_CTRL:   cfg_rdata <= {{(AW-2){1'b0}}, done_o, active};
        OFS_BASE_A: cfg_rdata <= base_a_o;
        OFS_BASE_B: cfg_rdata <= base_b_o;
        OFS_BASE_C: cfg_rdata <= base_c_o;
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  // R3
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !done_o);
  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !busy);
endmodule

// File: rtl/mfl_idx2d.sv
module mfl_idx2d #(
  parameter int ROWS = 4,
  parameter int COLS = 5,
  parameter int RW   = 2,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last
);
  localparam logic [RW-1:0] ROW_END = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_END = CW'(COLS - 1);

  assign last = (row == ROW_END) && (col == COL_END);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      if (col == COL_END) begin
        col <= '0;
        row <= (row == ROW_END) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(row) < ROWS) && (int'(col) < COLS));
endmodule

// File: rtl/mfl_rsp_slot.sv
module mfl_rsp_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          need,
  input  logic          retire,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          ready,
  output logic [DW-1:0] data
);
  logic          want;
  logic          got;
  logic [DW-1:0] held;

  assign ready = !want || got || rsp_valid;
  assign data  = got ? held : rsp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      want <= 1'b0;
      got  <= 1'b0;
      held <= '0;
    end else if (arm) begin
      want <= need;
      got  <= 1'b0;
    end else if (retire) begin
      want <= 1'b0;
      got  <= 1'b0;
    end else if (rsp_valid && want && !got) begin
      got  <= 1'b1;
      held <= rsp_data;
    end
  end

  // R7
  rsp_expected_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (want && !got));
endmodule

// File: rtl/matfuse_loader.sv
module matfuse_loader #(
  parameter int M  = 3,
  parameter int N  = 4,
  parameter int K  = 5,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int ES = 2,
  localparam int OUT_N = mfl_pkg::imax(M, N),
  localparam int IN_N  = mfl_pkg::imax(N, K),
  localparam int RW    = mfl_pkg::imax(1, $clog2(OUT_N)),
  localparam int CW    = mfl_pkg::imax(1, $clog2(IN_N))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          a_req_valid,
  output logic [AW-1:0] a_req_addr,
  input  logic          a_rsp_valid,
  input  logic [DW-1:0] a_rsp_data,
  output logic          b_req_valid,
  output logic [AW-1:0] b_req_addr,
  input  logic          b_rsp_valid,
  input  logic [DW-1:0] b_rsp_data,
  output logic          c_wr_valid,
  output logic [AW-1:0] c_wr_addr,
  output logic [DW-1:0] c_wr_data,
  output logic          a_buf_we,
  output logic [RW-1:0] a_buf_row,
  output logic [CW-1:0] a_buf_col,
  output logic [DW-1:0] a_buf_data,
  output logic          b_buf_we,
  output logic [RW-1:0] b_buf_row,
  output logic [CW-1:0] b_buf_col,
  output logic [DW-1:0] b_buf_data,
  output logic          c_clr_we,
  output logic [RW-1:0] c_clr_row,
  output logic [CW-1:0] c_clr_col,
  output logic          load_done,
  input  logic          calc_done,
  output logic          c_rd_en,
  output logic [RW-1:0] c_rd_row,
  output logic [CW-1:0] c_rd_col,
  input  logic [DW-1:0] c_rd_data
);
  import mfl_pkg::*;

  seq_st_t       st;
  logic          start;
  logic          done;
  logic          done_set;
  logic [AW-1:0] base_a, base_b, base_c;

  mfl_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(st != ST_IDLE),
    .done_set(done_set), .start_o(start), .base_a_o(base_a),
    .base_b_o(base_b), .base_c_o(base_c), .done_o(done)
  );

  // load grid walker
  logic [RW-1:0] lr;
  logic [CW-1:0] lc;
  logic          l_last;
  logic          retire;

  mfl_idx2d #(.ROWS(OUT_N), .COLS(IN_N), .RW(RW), .CW(CW)) u_load_idx (
    .clk(clk), .rst(rst), .clr(start), .step(retire),
    .row(lr), .col(lc), .last(l_last)
  );

  logic need_a, need_b, need_c;
  assign need_a = (int'(lr) < M) && (int'(lc) < N);
  assign need_b = (int'(lr) < N) && (int'(lc) < K);
  assign need_c = (int'(lr) < M) && (int'(lc) < K);

  // response slots, index 0 = A port, 1 = B port
  logic [1:0]    slot_need, slot_rv, slot_rdy;
  logic [DW-1:0] slot_rd [2];
  logic [DW-1:0] slot_q  [2];

  assign slot_need  = {need_b, need_a};
  assign slot_rv    = {b_rsp_valid, a_rsp_valid};
  assign slot_rd[0] = a_rsp_data;
  assign slot_rd[1] = b_rsp_data;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    mfl_rsp_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst(rst), .arm(st == ST_ISSUE), .need(slot_need[g]),
      .retire(retire), .rsp_valid(slot_rv[g]), .rsp_data(slot_rd[g]),
      .ready(slot_rdy[g]), .data(slot_q[g])
    );
  end

  assign retire = (st == ST_WAIT) && (&slot_rdy) && !a_req_valid && !b_req_valid;

  // write-back walker
  logic [RW-1:0] wr;
  logic [CW-1:0] wc;
  logic          w_last;

  mfl_idx2d #(.ROWS(M), .COLS(K), .RW(RW), .CW(CW)) u_wb_idx (
    .clk(clk), .rst(rst), .clr(start), .step(c_rd_en),
    .row(wr), .col(wc), .last(w_last)
  );

  assign c_rd_row = wr;
  assign c_rd_col = wc;

  logic          p_valid;
  logic [RW-1:0] p_r;
  logic [CW-1:0] p_c;

  assign done_set = (st == ST_DRAIN) && !p_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      a_req_valid <= 1'b0;
      a_req_addr  <= '0;
      b_req_valid <= 1'b0;
      b_req_addr  <= '0;
      a_buf_we    <= 1'b0;
      a_buf_row   <= '0;
      a_buf_col   <= '0;
      a_buf_data  <= '0;
      b_buf_we    <= 1'b0;
      b_buf_row   <= '0;
      b_buf_col   <= '0;
      b_buf_data  <= '0;
      c_clr_we    <= 1'b0;
      c_clr_row   <= '0;
      c_clr_col   <= '0;
      load_done   <= 1'b0;
      c_rd_en     <= 1'b0;
      p_valid     <= 1'b0;
      p_r         <= '0;
      p_c         <= '0;
      c_wr_valid  <= 1'b0;
      c_wr_addr   <= '0;
      c_wr_data   <= '0;
    end else begin
      a_req_valid <= 1'b0;
      b_req_valid <= 1'b0;
      a_buf_we    <= 1'b0;
      b_buf_we    <= 1'b0;
      c_clr_we    <= 1'b0;
      load_done   <= 1'b0;

      p_valid    <= c_rd_en;
      p_r        <= wr;
      p_c        <= wc;
      c_wr_valid <= p_valid;
      c_wr_addr  <= base_c + AW'((int'(p_r) * K + int'(p_c)) * ES);
      c_wr_data  <= c_rd_data;

      case (st)
        ST_IDLE: if (start) st <= ST_ISSUE;
        ST_ISSUE: begin
          a_req_valid <= need_a;
          b_req_valid <= need_b;
          a_req_addr  <= base_a + AW'((int'(lr) * N + int'(lc)) * ES);
          b_req_addr  <= base_b + AW'((int'(lr) * K + int'(lc)) * ES);
          st          <= ST_WAIT;
        end
        ST_WAIT: if (retire) begin
          a_buf_we   <= need_a;
          a_buf_row  <= lr;
          a_buf_col  <= lc;
          a_buf_data <= slot_q[0];
          b_buf_we   <= need_b;
          b_buf_row  <= lr;
          b_buf_col  <= lc;
          b_buf_data <= slot_q[1];
          c_clr_we   <= need_c;
          c_clr_row  <= lr;
          c_clr_col  <= lc;
          load_done  <= l_last;
          st         <= l_last ? ST_HOLD : ST_ISSUE;
        end
        ST_HOLD: if (calc_done) begin
          c_rd_en <= 1'b1;
          st      <= ST_WB;
        end
        ST_WB: if (w_last) begin
          c_rd_en <= 1'b0;
          st      <= ST_DRAIN;
        end
        ST_DRAIN: if (!p_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  load_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);
  // R9
  wb_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr_valid && $past(c_wr_valid)) |-> (c_wr_addr == $past(c_wr_addr) + AW'(ES)));
  // R9
  wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    c_wr_valid |-> (!a_req_valid && !b_req_valid));
  // R7
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    (a_buf_we && b_buf_we) |-> (a_buf_row == b_buf_row && a_buf_col == b_buf_col));
  // R4
  a_guard_chk: assert property (@(posedge clk) disable iff (rst)
    a_buf_we |-> ((int'(a_buf_row) < M) && (int'(a_buf_col) < N)));
  // R5
  b_guard_chk: assert property (@(posedge clk) disable iff (rst)
    b_buf_we |-> ((int'(b_buf_row) < N) && (int'(b_buf_col) < K)));
endmodule

// File: tb/test_matfuse_loader.sv
module test_matfuse_loader;
  localparam int M = 3, N = 4, K = 5, DW = 16, AW = 32, ES = 2;
  localparam int OUT_N = (M > N) ? M : N;
  localparam int IN_N  = (N > K) ? N : K;
  localparam int RW = 2, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic          cfg_we = 0;
  logic [5:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
  logic          a_req_valid, b_req_valid, c_wr_valid;
  logic [AW-1:0] a_req_addr, b_req_addr, c_wr_addr;
  logic          a_rsp_valid = 0, b_rsp_valid = 0;
  logic [DW-1:0] a_rsp_data = '0, b_rsp_data = '0, c_wr_data;
  logic          a_buf_we, b_buf_we, c_clr_we, load_done, c_rd_en;
  logic [RW-1:0] a_buf_row, b_buf_row, c_clr_row, c_rd_row;
  logic [CW-1:0] a_buf_col, b_buf_col, c_clr_col, c_rd_col;
  logic [DW-1:0] a_buf_data, b_buf_data;
  logic          calc_done = 0;
  logic [DW-1:0] c_rd_data = '0;

  matfuse_loader #(.M(M), .N(N), .K(K), .DW(DW), .AW(AW), .ES(ES)) i_matfuse_loader (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .a_req_valid(a_req_valid), .a_req_addr(a_req_addr),
    .a_rsp_valid(a_rsp_valid), .a_rsp_data(a_rsp_data), .b_req_valid(b_req_valid),
    .b_req_addr(b_req_addr), .b_rsp_valid(b_rsp_valid), .b_rsp_data(b_rsp_data),
    .c_wr_valid(c_wr_valid), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data),
    .a_buf_we(a_buf_we), .a_buf_row(a_buf_row), .a_buf_col(a_buf_col), .a_buf_data(a_buf_data),
    .b_buf_we(b_buf_we), .b_buf_row(b_buf_row), .b_buf_col(b_buf_col), .b_buf_data(b_buf_data),
    .c_clr_we(c_clr_we), .c_clr_row(c_clr_row), .c_clr_col(c_clr_col),
    .load_done(load_done), .calc_done(calc_done), .c_rd_en(c_rd_en),
    .c_rd_row(c_rd_row), .c_rd_col(c_rd_col), .c_rd_data(c_rd_data)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int lat_a = 1, lat_b = 1;
  int a_reqs, b_reqs, both_cnt, ld_cnt, ld_cyc, last_stb, idx_err;
  int wb_n, wb_err, wb_gap, wb_early, wb_prev;
  int a_cnt [OUT_N][IN_N], b_cnt [OUT_N][IN_N], c_cnt [OUT_N][IN_N];
  logic [DW-1:0] a_val [OUT_N][IN_N], b_val [OUT_N][IN_N];
  logic [AW-1:0] bA, bB, bC;

  function automatic logic [DW-1:0] pat_a(input logic [AW-1:0] ad);
    return DW'(ad * 3 + 32'h0101);
  endfunction
  function automatic logic [DW-1:0] pat_b(input logic [AW-1:0] ad);
    return DW'((ad ^ 32'h5A5A) + 32'h0007);
  endfunction
  function automatic logic [DW-1:0] pat_c(input int r, input int c);
    return DW'(32'h7000 ^ (r * 37 + c * 5));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin @(posedge clk); cyc++; end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // A port memory model
  initial forever begin
    @(negedge clk);
    if (a_req_valid) begin
      automatic logic [AW-1:0] ad = a_req_addr;
      a_reqs++;
      repeat (lat_a) @(negedge clk);
      a_rsp_valid = 1; a_rsp_data = pat_a(ad);
      @(negedge clk);
      a_rsp_valid = 0;
    end
  end

  // B port memory model
  initial forever begin
    @(negedge clk);
    if (b_req_valid) begin
      automatic logic [AW-1:0] ad = b_req_addr;
      b_reqs++;
      repeat (lat_b) @(negedge clk);
      b_rsp_valid = 1; b_rsp_data = pat_b(ad);
      @(negedge clk);
      b_rsp_valid = 0;
    end
  end

  // C buffer read model (one-cycle latency) and output monitors
  initial begin
    automatic bit pend = 0;
    automatic int pr = 0, pc = 0;
    forever begin
      @(negedge clk);
      c_rd_data = pend ? pat_c(pr, pc) : '0;
      pend = c_rd_en; pr = int'(c_rd_row); pc = int'(c_rd_col);
      if (a_buf_we) begin
        if (int'(a_buf_row) < OUT_N && int'(a_buf_col) < IN_N) begin
          a_cnt[a_buf_row][a_buf_col]++; a_val[a_buf_row][a_buf_col] = a_buf_data;
        end else idx_err++;
      end
      if (b_buf_we) begin
        if (int'(b_buf_row) < OUT_N && int'(b_buf_col) < IN_N) begin
          b_cnt[b_buf_row][b_buf_col]++; b_val[b_buf_row][b_buf_col] = b_buf_data;
        end else idx_err++;
      end
      if (c_clr_we) begin
        if (int'(c_clr_row) < OUT_N && int'(c_clr_col) < IN_N) c_cnt[c_clr_row][c_clr_col]++;
        else idx_err++;
      end
      if (a_buf_we && b_buf_we) both_cnt++;
      if (a_buf_we || b_buf_we || c_clr_we) last_stb = cyc;
      if (load_done) begin ld_cnt++; ld_cyc = cyc; end
      if (c_wr_valid) begin
        if (ld_cnt == 0) wb_early++;
        if (c_wr_addr != bC + AW'(wb_n * ES)) wb_err++;
        if (c_wr_data != pat_c(wb_n / K, wb_n % K)) wb_err++;
        if (wb_n > 0 && cyc != wb_prev + 1) wb_gap++;
        wb_prev = cyc; wb_n++;
      end
    end
  end

  task automatic cfg_write(input logic [5:0] ad, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [5:0] ad, output logic [AW-1:0] d);
    @(negedge clk); cfg_addr = ad;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [AW-1:0] d;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    chk(!a_req_valid && !b_req_valid && !c_wr_valid && !load_done && !c_rd_en,
        "reset outputs idle R9", {a_req_valid, b_req_valid, c_wr_valid}, 0);
    cfg_read(6'h00, d); chk(d == 0, "reset ctrl R3", d, 0);
    cfg_read(6'h10, d); chk(d == 0, "reset base A R1", d, 0);
  endtask

  task automatic t_regs();
    logic [AW-1:0] d;
    cfg_write(6'h10, 32'h0000_1000);
    cfg_write(6'h1C, 32'h0000_2000);
    cfg_write(6'h28, 32'h0000_3000);
    cfg_read(6'h10, d); chk(d == 32'h1000, "base A readback R1", d, 32'h1000);
    cfg_read(6'h1C, d); chk(d == 32'h2000, "base B readback R1", d, 32'h2000);
    cfg_read(6'h28, d); chk(d == 32'h3000, "base C readback R1", d, 32'h3000);
    cfg_read(6'h04, d); chk(d == 0, "unmapped offset R1", d, 0);
  endtask

  task automatic t_run(input int la, input int lb, input logic [AW-1:0] base, input bit poke);
    logic [AW-1:0] d;
    int ea, eb, ec, exp_both;
    lat_a = la; lat_b = lb;
    bA = base; bB = base + 32'h1000; bC = base + 32'h2000;
    a_reqs = 0; b_reqs = 0; both_cnt = 0; ld_cnt = 0; idx_err = 0;
    wb_n = 0; wb_err = 0; wb_gap = 0; wb_early = 0;
    for (int i = 0; i < OUT_N; i++)
      for (int j = 0; j < IN_N; j++) begin a_cnt[i][j] = 0; b_cnt[i][j] = 0; c_cnt[i][j] = 0; end
    cfg_write(6'h10, bA); cfg_write(6'h1C, bB); cfg_write(6'h28, bC);
    cfg_write(6'h00, 32'h1);
    cfg_read(6'h00, d);
    chk(d == 32'h1, "start sets busy clears done R2 R3", d, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      cfg_write(6'h00, 32'h1);          // ignored while busy (R2)
      calc_done = 1; @(negedge clk); calc_done = 0;   // ignored before load end (R9)
    end
    while (ld_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    cfg_read(6'h00, d); chk(d == 32'h1, "holding busy not done R3", d, 1);
    chk(wb_n == 0 && wb_early == 0, "no write-back before calc_done R9", wb_n, 0);
    calc_done = 1; @(negedge clk); calc_done = 0;
    while (wb_n < M * K) @(negedge clk);
    repeat (4) @(negedge clk);
    cfg_read(6'h00, d); chk(d == 32'h2, "done after write-back R3", d, 2);
    ea = 0; eb = 0; ec = 0; exp_both = 0;
    for (int i = 0; i < OUT_N; i++)
      for (int j = 0; j < IN_N; j++) begin
        automatic bit ga = (i < M) && (j < N);
        automatic bit gb = (i < N) && (j < K);
        automatic bit gc = (i < M) && (j < K);
        if (a_cnt[i][j] != (ga ? 1 : 0)) ea++;
        else if (ga && a_val[i][j] != pat_a(bA + AW'((i * N + j) * ES))) ea++;
        if (b_cnt[i][j] != (gb ? 1 : 0)) eb++;
        else if (gb && b_val[i][j] != pat_b(bB + AW'((i * K + j) * ES))) eb++;
        if (c_cnt[i][j] != (gc ? 1 : 0)) ec++;
        if (ga && gb) exp_both++;
      end
    chk(ea == 0 && idx_err == 0, "A cells guarded and addressed R4", ea, 0);
    chk(a_reqs == M * N, "A request count R4", a_reqs, M * N);
    chk(eb == 0, "B cells guarded and addressed R5", eb, 0);
    chk(b_reqs == N * K, "B request count R5", b_reqs, N * K);
    chk(ec == 0, "C clear cells R6", ec, 0);
    chk(both_cnt == exp_both, "A and B strobes share cycle R7", both_cnt, exp_both);
    chk(ld_cnt == 1, "load_done single pulse R8", ld_cnt, 1);
    chk(ld_cyc == last_stb, "load_done with last strobe R8", ld_cyc, last_stb);
    chk(wb_n == M * K && wb_err == 0, "write-back address and data R9", wb_err, 0);
    chk(wb_gap == 0, "write-back one per cycle R9", wb_gap, 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_run(1, 1, 32'h0000_1000, 1'b0);
    t_run(1, 4, 32'h0000_4400, 1'b1);
    t_run(5, 2, 32'h0001_0000, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule